// File: doc/BRIEF.md
# Transactional Read/Write Set Tracker

This block sits beside a small direct-mapped cache tag array and records which cached lines a hardware transaction has touched. Each line holds a valid bit, a dirty bit, a speculative-read mark and a speculative-write mark. A begin command opens a transaction. Loads and stores made while it is open set the marks. Coherence probes from other agents are compared against the marks, and a probe that collides with the transaction's footprint ends it with a conflict abort.

A commit clears every mark at once and keeps the written data. An abort, whether commanded or raised by the tracker, drops every line the transaction wrote. The previous committed value of such a line is still held further out, because the tracker asks for a writeback of a dirty line before the transaction first writes to it. A transactional miss that would displace a marked line cannot be tracked, so the tracker aborts with an overflow cause instead of performing the access.

Top module: `txs_tracker`

## Requirements
- R1: After synchronous reset, no line is valid, `in_tx_o`, `abort_o` and `wb_valid_o` are 0, and `hit_o` is 0 for every address.
- R2: `hit_o` is combinational and is 1 when the line selected by the low `$clog2(LINES)` bits of `acc_addr_i` is valid and its stored tag equals the upper bits. A miss allocates that line; a store marks it dirty.
- R3: A load inside a transaction marks its line as read. A later probe of kind write (1) or invalidate (2) to that line raises `abort_o` with cause 1 (conflict) in the cycle after the probe and closes the transaction. A read probe (0) to a line that is only read-marked does not abort.
- R4: A store inside a transaction marks its line as written. A later probe of any kind to that line raises a conflict abort (cause 1).
- R5: A transactional store that hits a dirty line not yet write-marked pulses `wb_valid_o`, with `wb_addr_o` set to that line's address, in the following cycle. Further stores to the same line in the same transaction request nothing.
- R6: A commit command (code 2) inside a transaction closes it in the next cycle and clears every mark. Written lines stay valid, and later probes to them raise no abort.
- R7: On an abort, every write-marked line becomes invalid and lines that were only read-marked stay valid, all within the cycle after the abort. A commanded abort (code 3) reports cause 3.
- R8: A transactional miss whose victim line carries a read or write mark is not performed. Instead it raises `abort_o` with cause 2 (overflow), and the victim stays valid if it was only read-marked.
- R9: Loads and stores made outside a transaction set no marks, so later probes to those lines inside a transaction raise no abort.
- R10: A write or invalidate probe that matches a valid line invalidates it.
- R11: A miss that evicts a valid dirty line pulses `wb_valid_o` in the next cycle, with `wb_addr_o` set to the evicted line's address.
- R12: A begin (code 1) inside a transaction, and a commit or abort outside one, change nothing and raise no abort.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cmd_i | input | 2 | 0 none, 1 begin, 2 commit, 3 abort |
| acc_valid_i | input | 1 | Local access present |
| acc_write_i | input | 1 | 1 store, 0 load |
| acc_addr_i | input | ADDR_W | Line address of the local access, also drives the `hit_o` lookup |
| probe_valid_i | input | 1 | External coherence probe present |
| probe_kind_i | input | 2 | 0 read, 1 write, 2 invalidate |
| probe_addr_i | input | ADDR_W | Line address of the probe |
| hit_o | output | 1 | Lookup result for `acc_addr_i` |
| in_tx_o | output | 1 | A transaction is open |
| abort_o | output | 1 | One-cycle abort pulse |
| abort_cause_o | output | 2 | 1 conflict, 2 overflow, 3 commanded |
| wb_valid_o | output | 1 | One-cycle writeback request |
| wb_addr_o | output | ADDR_W | Line address to write back |

## Verification
The assertions assume that at most one of command, probe and local access is presented in any cycle. If they overlap, a command takes precedence over a probe, and a probe takes precedence over an access. The assertions also assume that the probe kind never carries the unused code 3. The directed stimulus drives each operation alone for one clock, then returns all valids to idle and the command to 0 before the next operation, so it stays inside these assumptions.

// File: rtl/txs_pkg.sv
package txs_pkg;

    typedef enum logic [1:0] {
        CMD_NONE   = 2'd0,
        CMD_BEGIN  = 2'd1,
        CMD_COMMIT = 2'd2,
        CMD_ABORT  = 2'd3
    } cmd_e;

    typedef enum logic [1:0] {
        PRB_READ  = 2'd0,
        PRB_WRITE = 2'd1,
        PRB_INVAL = 2'd2
    } probe_e;

    typedef enum logic [1:0] {
        CAUSE_NONE     = 2'd0,
        CAUSE_CONFLICT = 2'd1,
        CAUSE_OVERFLOW = 2'd2,
        CAUSE_EXPLICIT = 2'd3
    } cause_e;

    typedef struct packed {
        logic valid;
        logic dirty;
        logic rd;
        logic wr;
    } flags_t;

    // A probe that takes ownership or kills the copy
    function automatic logic probe_kills(input logic [1:0] kind);
        return (kind == PRB_WRITE) || (kind == PRB_INVAL);
    endfunction

endpackage

// File: rtl/txs_line.sv
module txs_line
    import txs_pkg::*;
#(
    parameter int TAG_W = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             upd_en,
    input  flags_t           upd_flags,
    input  logic [TAG_W-1:0] upd_tag,
    input  logic             commit_clr,
    input  logic             abort_clr,
    output flags_t           flags_o,
    output logic [TAG_W-1:0] tag_o
);

    flags_t           flags_q, base, nxt;
    logic [TAG_W-1:0] tag_q;

    always_comb begin
        base = upd_en ? upd_flags : flags_q;
        nxt  = base;
        if (abort_clr && base.wr) begin
            nxt.valid = 1'b0;
            nxt.dirty = 1'b0;
        end
        if (abort_clr || commit_clr) begin
            nxt.rd = 1'b0;
            nxt.wr = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            flags_q <= '0;
            tag_q   <= '0;
        end else begin
            flags_q <= nxt;
            if (upd_en) tag_q <= upd_tag;
        end
    end

    assign flags_o = flags_q;
    assign tag_o   = tag_q;

    // R6
    commit_clears_chk: assert property (@(posedge clk) disable iff (rst)
        commit_clr |=> (!flags_q.rd && !flags_q.wr));

    // R7
    abort_drops_written_chk: assert property (@(posedge clk) disable iff (rst)
        (abort_clr && !upd_en && flags_q.wr) |=> !flags_q.valid);

    // R7
    abort_keeps_read_chk: assert property (@(posedge clk) disable iff (rst)
        (abort_clr && !upd_en && flags_q.valid && !flags_q.wr) |=> flags_q.valid);

endmodule

// File: rtl/txs_ctrl.sv
module txs_ctrl
    import txs_pkg::*;
#(
    parameter int LINES  = 8,
    parameter int ADDR_W = 8,
    localparam int IDX_W = $clog2(LINES),
    localparam int TAG_W = ADDR_W - IDX_W
) (
    input  flags_t              flags [LINES],
    input  logic [TAG_W-1:0]    tags  [LINES],
    input  logic                in_tx,
    input  logic [1:0]          cmd,
    input  logic                acc_valid,
    input  logic                acc_write,
    input  logic [ADDR_W-1:0]   acc_addr,
    input  logic                probe_valid,
    input  logic [1:0]          probe_kind,
    input  logic [ADDR_W-1:0]   probe_addr,
    output logic                hit,
    output logic                upd_en,
    output logic [IDX_W-1:0]    upd_idx,
    output flags_t              upd_flags,
    output logic [TAG_W-1:0]    upd_tag,
    output logic                commit_clr,
    output logic                abort_clr,
    output logic                nx_tx,
    output logic [1:0]          abort_cause,
    output logic                wb_req,
    output logic [ADDR_W-1:0]   wb_addr
);

    logic [IDX_W-1:0] a_idx, p_idx;
    logic [TAG_W-1:0] a_tag, p_tag;
    flags_t           a_ln, p_ln, fresh;
    logic             p_match, cmd_act;

    assign a_idx = acc_addr[IDX_W-1:0];
    assign a_tag = acc_addr[ADDR_W-1:IDX_W];
    assign p_idx = probe_addr[IDX_W-1:0];
    assign p_tag = probe_addr[ADDR_W-1:IDX_W];
    assign a_ln  = flags[a_idx];
    assign p_ln  = flags[p_idx];
    assign hit     = a_ln.valid && (tags[a_idx] == a_tag);
    assign p_match = p_ln.valid && (tags[p_idx] == p_tag);

    always_comb begin
        cmd_act = 1'b0;
        case (cmd_e'(cmd))
            CMD_BEGIN:  cmd_act = !in_tx;
            CMD_COMMIT: cmd_act = in_tx;
            CMD_ABORT:  cmd_act = in_tx;
            default:    cmd_act = 1'b0;
        endcase
    end

    always_comb begin
        upd_en      = 1'b0;
        upd_idx     = a_idx;
        upd_flags   = a_ln;
        upd_tag     = a_tag;
        commit_clr  = 1'b0;
        abort_clr   = 1'b0;
        nx_tx       = in_tx;
        abort_cause = CAUSE_NONE;
        wb_req      = 1'b0;
        wb_addr     = acc_addr;
        fresh       = '0;

        if (cmd_act) begin
            if (cmd == CMD_BEGIN) begin
                nx_tx = 1'b1;
            end else if (cmd == CMD_COMMIT) begin
                commit_clr = 1'b1;
                nx_tx      = 1'b0;
            end else begin
                abort_clr   = 1'b1;
                nx_tx       = 1'b0;
                abort_cause = CAUSE_EXPLICIT;
            end
        end else if (probe_valid) begin
            if (p_match && probe_kills(probe_kind)) begin
                upd_en    = 1'b1;
                upd_idx   = p_idx;
                upd_flags = '0;
                upd_tag   = p_tag;
            end
            if (p_match && in_tx &&
                (p_ln.wr || (p_ln.rd && probe_kills(probe_kind)))) begin
                abort_clr   = 1'b1;
                nx_tx       = 1'b0;
                abort_cause = CAUSE_CONFLICT;
            end
        end else if (acc_valid) begin
            if (hit) begin
                upd_en    = 1'b1;
                upd_flags = a_ln;
                if (acc_write) begin
                    wb_req          = in_tx && a_ln.dirty && !a_ln.wr;
                    upd_flags.dirty = 1'b1;
                    upd_flags.wr    = a_ln.wr || in_tx;
                end else begin
                    upd_flags.rd    = a_ln.rd || in_tx;
                end
            end else if (in_tx && a_ln.valid && (a_ln.rd || a_ln.wr)) begin
                abort_clr   = 1'b1;
                nx_tx       = 1'b0;
                abort_cause = CAUSE_OVERFLOW;
            end else begin
                wb_req      = a_ln.valid && a_ln.dirty;
                wb_addr     = {tags[a_idx], a_idx};
                fresh.valid = 1'b1;
                fresh.dirty = acc_write;
                fresh.rd    = in_tx && !acc_write;
                fresh.wr    = in_tx && acc_write;
                upd_en      = 1'b1;
                upd_flags   = fresh;
            end
        end
    end

endmodule

// File: rtl/txs_tracker.sv
module txs_tracker
    import txs_pkg::*;
#(
    parameter int LINES  = 8,
    parameter int ADDR_W = 8,
    localparam int IDX_W = $clog2(LINES),
    localparam int TAG_W = ADDR_W - IDX_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        cmd_i,
    input  logic              acc_valid_i,
    input  logic              acc_write_i,
    input  logic [ADDR_W-1:0] acc_addr_i,
    input  logic              probe_valid_i,
    input  logic [1:0]        probe_kind_i,
    input  logic [ADDR_W-1:0] probe_addr_i,
    output logic              hit_o,
    output logic              in_tx_o,
    output logic              abort_o,
    output logic [1:0]        abort_cause_o,
    output logic              wb_valid_o,
    output logic [ADDR_W-1:0] wb_addr_o
);

    flags_t             flags [LINES];
    logic [TAG_W-1:0]   tags  [LINES];
    logic               upd_en, commit_clr, abort_clr, nx_tx, wb_req;
    logic [IDX_W-1:0]   upd_idx;
    flags_t             upd_flags;
    logic [TAG_W-1:0]   upd_tag;
    logic [1:0]         cause;
    logic [ADDR_W-1:0]  wb_addr;

    txs_ctrl #(.LINES(LINES), .ADDR_W(ADDR_W)) u_ctrl (
        .flags(flags), .tags(tags), .in_tx(in_tx_o), .cmd(cmd_i),
        .acc_valid(acc_valid_i), .acc_write(acc_write_i), .acc_addr(acc_addr_i),
        .probe_valid(probe_valid_i), .probe_kind(probe_kind_i),
        .probe_addr(probe_addr_i), .hit(hit_o), .upd_en(upd_en),
        .upd_idx(upd_idx), .upd_flags(upd_flags), .upd_tag(upd_tag),
        .commit_clr(commit_clr), .abort_clr(abort_clr), .nx_tx(nx_tx),
        .abort_cause(cause), .wb_req(wb_req), .wb_addr(wb_addr)
    );

    for (genvar g = 0; g < LINES; g++) begin : g_line
        txs_line #(.TAG_W(TAG_W)) u_line (
            .clk(clk), .rst(rst),
            .upd_en(upd_en && (upd_idx == IDX_W'(g))),
            .upd_flags(upd_flags), .upd_tag(upd_tag),
            .commit_clr(commit_clr), .abort_clr(abort_clr),
            .flags_o(flags[g]), .tag_o(tags[g])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            in_tx_o       <= 1'b0;
            abort_o       <= 1'b0;
            abort_cause_o <= CAUSE_NONE;
            wb_valid_o    <= 1'b0;
            wb_addr_o     <= '0;
        end else begin
            in_tx_o       <= nx_tx;
            abort_o       <= abort_clr;
            abort_cause_o <= cause;
            wb_valid_o    <= wb_req;
            wb_addr_o     <= wb_addr;
        end
    end

    // R7
    abort_closes_tx_chk: assert property (@(posedge clk) disable iff (rst)
        abort_o |-> (!in_tx_o && $past(in_tx_o)));

    // R3
    abort_has_cause_chk: assert property (@(posedge clk) disable iff (rst)
        abort_o |-> (abort_cause_o != CAUSE_NONE));

    // R12
    begin_nested_chk: assert property (@(posedge clk) disable iff (rst)
        (in_tx_o && cmd_i == CMD_BEGIN) |=> !abort_o);

    // R5
    wb_from_access_chk: assert property (@(posedge clk) disable iff (rst)
        wb_valid_o |-> $past(acc_valid_i));

    // R6
    commit_ends_chk: assert property (@(posedge clk) disable iff (rst)
        (in_tx_o && cmd_i == CMD_COMMIT) |=> (!in_tx_o && !abort_o));

endmodule

// File: tb/sim_txs_tracker.sv
module sim_txs_tracker;
    import txs_pkg::*;

    localparam int AW = 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [1:0]    cmd_i = 2'd0;
    logic          acc_valid_i = 1'b0, acc_write_i = 1'b0;
    logic [AW-1:0] acc_addr_i = '0;
    logic          probe_valid_i = 1'b0;
    logic [1:0]    probe_kind_i = 2'd0;
    logic [AW-1:0] probe_addr_i = '0;
    logic          hit_o, in_tx_o, abort_o, wb_valid_o;
    logic [1:0]    abort_cause_o;
    logic [AW-1:0] wb_addr_o;

    int n_chk = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    txs_tracker #(.LINES(8), .ADDR_W(AW)) u0 (
        .clk(clk), .rst(rst), .cmd_i(cmd_i),
        .acc_valid_i(acc_valid_i), .acc_write_i(acc_write_i), .acc_addr_i(acc_addr_i),
        .probe_valid_i(probe_valid_i), .probe_kind_i(probe_kind_i),
        .probe_addr_i(probe_addr_i), .hit_o(hit_o), .in_tx_o(in_tx_o),
        .abort_o(abort_o), .abort_cause_o(abort_cause_o),
        .wb_valid_o(wb_valid_o), .wb_addr_o(wb_addr_o)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Each operation: drive after a falling edge, clock once, sample at the next falling edge
    task automatic op_cmd(input logic [1:0] c);
        cmd_i = c;
        @(posedge clk); @(negedge clk);
        cmd_i = 2'd0;
    endtask

    task automatic op_acc(input logic we, input logic [AW-1:0] a);
        acc_valid_i = 1'b1; acc_write_i = we; acc_addr_i = a;
        @(posedge clk); @(negedge clk);
        acc_valid_i = 1'b0; acc_write_i = 1'b0;
    endtask

    task automatic op_probe(input logic [1:0] k, input logic [AW-1:0] a);
        probe_valid_i = 1'b1; probe_kind_i = k; probe_addr_i = a;
        @(posedge clk); @(negedge clk);
        probe_valid_i = 1'b0; probe_kind_i = 2'd0;
    endtask

    task automatic peek(input string req, input logic [AW-1:0] a, input int exp);
        acc_addr_i = a;
        #1;
        chk(req, int'(hit_o), exp);
    endtask

    task automatic t_reset;
        chk("R1 in_tx", int'(in_tx_o), 0);
        chk("R1 abort", int'(abort_o), 0);
        chk("R1 wb", int'(wb_valid_o), 0);
        peek("R1 hit", 8'h05, 0);
    endtask

    task automatic t_fill;
        op_acc(1'b1, 8'h11);
        chk("R11 no wb on empty victim", int'(wb_valid_o), 0);
        peek("R2 hit after fill", 8'h11, 1);
        peek("R2 other tag misses", 8'h19, 0);
    endtask

    task automatic t_read_conflict;
        op_cmd(CMD_BEGIN);
        chk("R3 begin", int'(in_tx_o), 1);
        op_acc(1'b0, 8'h1A);
        chk("R3 load no abort", int'(abort_o), 0);
        op_probe(PRB_WRITE, 8'h1A);
        chk("R3 abort", int'(abort_o), 1);
        chk("R3 cause", int'(abort_cause_o), 1);
        chk("R3 tx closed", int'(in_tx_o), 0);
        peek("R10 probed line gone", 8'h1A, 0);
    endtask

    task automatic t_commit_read;
        op_cmd(CMD_BEGIN);
        op_acc(1'b0, 8'h12);
        op_cmd(CMD_COMMIT);
        chk("R6 commit closes", int'(in_tx_o), 0);
        chk("R6 commit no abort", int'(abort_o), 0);
        peek("R6 line kept", 8'h12, 1);
        op_cmd(CMD_BEGIN);
        op_probe(PRB_INVAL, 8'h12);
        chk("R6 read mark cleared", int'(abort_o), 0);
        peek("R10 inval drops line", 8'h12, 0);
        op_cmd(CMD_COMMIT);
    endtask

    task automatic t_clean_then_abort;
        op_cmd(CMD_BEGIN);
        op_acc(1'b1, 8'h11);
        chk("R5 wb request", int'(wb_valid_o), 1);
        chk("R5 wb addr", int'(wb_addr_o), 'h11);
        op_acc(1'b1, 8'h11);
        chk("R5 second store no wb", int'(wb_valid_o), 0);
        op_acc(1'b0, 8'h13);
        op_cmd(CMD_ABORT);
        chk("R7 abort pulse", int'(abort_o), 1);
        chk("R7 cause", int'(abort_cause_o), 3);
        chk("R7 tx closed", int'(in_tx_o), 0);
        peek("R7 written line dropped", 8'h11, 0);
        peek("R7 read line kept", 8'h13, 1);
    endtask

    task automatic t_write_conflict;
        op_cmd(CMD_BEGIN);
        op_acc(1'b1, 8'h14);
        op_probe(PRB_READ, 8'h14);
        chk("R4 abort", int'(abort_o), 1);
        chk("R4 cause", int'(abort_cause_o), 1);
        peek("R7 written line dropped", 8'h14, 0);
    endtask

    task automatic t_read_probe_ok;
        op_cmd(CMD_BEGIN);
        op_acc(1'b0, 8'h13);
        op_probe(PRB_READ, 8'h13);
        chk("R3 read probe no abort", int'(abort_o), 0);
        chk("R3 still in tx", int'(in_tx_o), 1);
        peek("R3 line stays", 8'h13, 1);
        op_cmd(CMD_COMMIT);
    endtask

    task automatic t_overflow;
        op_cmd(CMD_BEGIN);
        op_acc(1'b0, 8'h08);
        op_acc(1'b0, 8'h10);
        chk("R8 abort", int'(abort_o), 1);
        chk("R8 cause", int'(abort_cause_o), 2);
        peek("R8 access dropped", 8'h10, 0);
        peek("R8 victim kept", 8'h08, 1);
    endtask

    task automatic t_plain_access;
        op_acc(1'b0, 8'h15);
        op_acc(1'b1, 8'h0E);
        op_cmd(CMD_BEGIN);
        op_probe(PRB_WRITE, 8'h15);
        chk("R9 plain load unmarked", int'(abort_o), 0);
        op_probe(PRB_READ, 8'h0E);
        chk("R9 plain store unmarked", int'(abort_o), 0);
        chk("R9 tx open", int'(in_tx_o), 1);
        op_cmd(CMD_COMMIT);
    endtask

    task automatic t_commit_write;
        op_cmd(CMD_BEGIN);
        op_acc(1'b1, 8'h16);
        op_cmd(CMD_COMMIT);
        peek("R6 written line kept", 8'h16, 1);
        op_cmd(CMD_BEGIN);
        op_probe(PRB_READ, 8'h16);
        chk("R6 write mark cleared", int'(abort_o), 0);
        op_cmd(CMD_COMMIT);
    endtask

    task automatic t_victim_wb;
        op_acc(1'b1, 8'h17);
        op_acc(1'b0, 8'h1F);
        chk("R11 victim wb", int'(wb_valid_o), 1);
        chk("R11 victim addr", int'(wb_addr_o), 'h17);
    endtask

    task automatic t_ignored_cmds;
        op_cmd(CMD_ABORT);
        chk("R12 abort outside tx", int'(abort_o), 0);
        op_cmd(CMD_COMMIT);
        chk("R12 commit outside tx", int'(in_tx_o), 0);
        op_cmd(CMD_BEGIN);
        op_cmd(CMD_BEGIN);
        chk("R12 nested begin", int'(in_tx_o), 1);
        chk("R12 nested begin no abort", int'(abort_o), 0);
        op_cmd(CMD_COMMIT);
        chk("R12 closes", int'(in_tx_o), 0);
    endtask

    initial begin
        fork
            begin
                repeat (3) @(posedge clk);
                @(negedge clk);
                rst = 1'b0;
                @(negedge clk);
                t_reset();
                t_fill();
                t_read_conflict();
                t_commit_read();
                t_clean_then_abort();
                t_write_conflict();
                t_read_probe_ok();
                t_overflow();
                t_plain_access();
                t_commit_write();
                t_victim_wb();
                t_ignored_cmds();
            end
            begin
                repeat (20000) @(posedge clk);
                n_chk++;
                n_fail++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule